// File: doc/BRIEF.md
# Video RAM-DAC Power-Up Initialization Sequencer

This controller runs once after reset and brings a video RAM-DAC into a known operating state over its 8-bit microprocessor port. It drives the data byte, a two-bit register select, a read/write level and an active-high write strobe. Every access is a write. Each write holds the select and data lines steady for a set number of clock cycles before the strobe and for a set number after it.

The sequence has three parts. First it toggles bits of the mode register: it clears and then sets bit 0 to reset the pixel pipelines, then raises and clears bit 5 to align the load timing. Next it sets the pixel mask and the three command registers. For each one it writes the register's address to the address register and then writes the value through the control-register select. Last, it points the address register at the palette and loads a linear ramp into all entries. Each entry gets a red, a green and a blue write, and all three carry the entry index. The ramp comes from an index counter and a colour-phase counter, not from a stored list. The block shows a busy level while the sequence runs and a done flag afterwards. The done flag stays set until the next reset.

A start pulse launches the sequence. A parameter can instead launch it on the first cycle after reset. Setup, strobe and hold lengths, the palette index width and the values written to the mask and command registers are all parameters.

Top module: `rdac_init_seq`

## Requirements
- R1: While reset is held and after it is released with no start, the outputs are data 00h, select 00, write strobe 0, read/write level 1, busy 0 and done 0, and no strobe occurs.
- R2: A start pulse sampled at a rising edge, with the block idle and not done, makes busy high from the next cycle on.
- R3: The first five writes use select 11 (mode register) and carry 09h, 08h, 09h, 29h, 09h in that order.
- R4: Writes 6 to 13 alternate select 00 (address register) and select 10 (control register), as pairs 04h/FFh, 05h/00h, 06h/ECh and 07h/C0h.
- R5: Write 14 puts 00h on select 00. It is followed by 768 writes on select 01 (palette). Write k of these carries data k/3, so entries 00h to FFh each get three writes, for red, green and blue. The total is 782 writes.
- R6: Select and data are stable for at least SETUP_CYC cycles before each strobe rises and while it is high. Each strobe is high for exactly STROBE_CYC cycles.
- R7: After each strobe falls, select and data stay unchanged for at least HOLD_CYC cycles.
- R8: The read/write level is 0 at every strobe and 1 whenever busy is low.
- R9: Done rises STROBE_CYC+HOLD_CYC+1 cycles after the last strobe rises. While done is high, busy is low, and done stays high until reset.
- R10: Start pulses during the sequence or after done change nothing. The write list is unchanged, and no strobe follows done.
- R11: Reset in the middle of the sequence returns all outputs to the R1 state. No strobe follows until a new start, and that start replays the list from the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; launches the sequence when idle |
| bus_data_o | output | 8 | Data byte to the RAM-DAC port |
| bus_sel_o | output | 2 | Register select: 11 mode, 00 address, 10 control, 01 palette |
| bus_rnw_o | output | 1 | Read/write level, 0 during the sequence |
| bus_wr_o | output | 1 | Write strobe, active high |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete, held until reset |

## Verification
A monitor samples on falling clock edges and tracks how many samples select and data have stayed unchanged. This lets it judge the setup window when a strobe rises, the strobe width when it falls, and the hold window at the next data change, all as sample counts. Each strobe is compared against the bench's own list of expected writes. Busy is due one cycle after a sampled start, and done is due exactly STROBE_CYC+HOLD_CYC+1 samples after the last strobe rises, so the bench samples and checks at those cycles. Random start pulses are fired through the run and after completion, and a reset lands at a random point mid-sequence.

// File: rtl/rdac_init_pkg.sv
package rdac_init_pkg;

   typedef enum logic [1:0] {
      SEL_ADDR = 2'b00,
      SEL_PAL  = 2'b01,
      SEL_CTRL = 2'b10,
      SEL_MODE = 2'b11
   } rdac_sel_e;

   typedef struct packed {
      rdac_sel_e   sel;
      logic [7:0]  data;
   } rdac_word_t;

   localparam int unsigned BUS_W       = 8;
   localparam int unsigned FIXED_STEPS = 14;
   localparam int unsigned STEP_W      = $clog2(FIXED_STEPS);
   localparam int unsigned COLOR_CNT   = 3;

endpackage

// File: rtl/rdac_fixed_steps.sv
module rdac_fixed_steps
   import rdac_init_pkg::*;
#(
   parameter logic [7:0] MASK_VAL = 8'hFF,
   parameter logic [7:0] CMD1_VAL = 8'h00,
   parameter logic [7:0] CMD2_VAL = 8'hEC,
   parameter logic [7:0] CMD3_VAL = 8'hC0
)
(
   input  logic [STEP_W-1:0] step_i,
   output rdac_word_t        word_o,
   output logic              last_o
);

   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(FIXED_STEPS - 1);

   // mode toggles: bit0 1->0->1 (pipeline reset), bit5 0->1->0 (load timing)
   always_comb begin
      word_o = '{sel: SEL_ADDR, data: 8'h00};
      case (step_i)
         4'd0:    word_o = '{sel: SEL_MODE, data: 8'h09};
         4'd1:    word_o = '{sel: SEL_MODE, data: 8'h08};
         4'd2:    word_o = '{sel: SEL_MODE, data: 8'h09};
         4'd3:    word_o = '{sel: SEL_MODE, data: 8'h29};
         4'd4:    word_o = '{sel: SEL_MODE, data: 8'h09};
         4'd5:    word_o = '{sel: SEL_ADDR, data: 8'h04};
         4'd6:    word_o = '{sel: SEL_CTRL, data: MASK_VAL};
         4'd7:    word_o = '{sel: SEL_ADDR, data: 8'h05};
         4'd8:    word_o = '{sel: SEL_CTRL, data: CMD1_VAL};
         4'd9:    word_o = '{sel: SEL_ADDR, data: 8'h06};
         4'd10:   word_o = '{sel: SEL_CTRL, data: CMD2_VAL};
         4'd11:   word_o = '{sel: SEL_ADDR, data: 8'h07};
         4'd12:   word_o = '{sel: SEL_CTRL, data: CMD3_VAL};
         default: word_o = '{sel: SEL_ADDR, data: 8'h00};
      endcase
   end

   assign last_o = (step_i == LAST_STEP);

endmodule

// File: rtl/rdac_ramp_gen.sv
module rdac_ramp_gen
   import rdac_init_pkg::*;
#(
   parameter int unsigned IDX_W = 8
)
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       adv_i,
   output rdac_word_t word_o,
   output logic       last_o
);

   localparam logic [1:0]       LAST_PHASE = 2'(COLOR_CNT - 1);
   localparam logic [IDX_W-1:0] LAST_IDX   = {IDX_W{1'b1}};

   if (IDX_W < 1 || IDX_W > BUS_W) begin : g_bad_idx
      $error("rdac_ramp_gen: IDX_W must be 1..8");
   end

   logic [IDX_W-1:0] idx_q;
   logic [1:0]       phase_q;
   logic [7:0]       data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         phase_q <= '0;
      end else if (adv_i) begin
         if (phase_q == LAST_PHASE) begin
            phase_q <= '0;
            idx_q   <= idx_q + 1'b1;
         end else begin
            phase_q <= phase_q + 2'd1;
         end
      end
   end

   if (IDX_W == BUS_W) begin : g_full
      assign data = idx_q;
   end else begin : g_narrow
      assign data = {{(BUS_W - IDX_W){1'b0}}, idx_q};
   end

   assign word_o = '{sel: SEL_PAL, data: data};
   assign last_o = (phase_q == LAST_PHASE) && (idx_q == LAST_IDX);

   assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q != 2'd3);

   assert_phase_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && phase_q == LAST_PHASE) |=> (phase_q == 2'd0));

endmodule

// File: rtl/rdac_bus_writer.sv
module rdac_bus_writer
   import rdac_init_pkg::*;
#(
   parameter int unsigned SETUP_CYC  = 2,
   parameter int unsigned STROBE_CYC = 1,
   parameter int unsigned HOLD_CYC   = 1
)
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_i,
   input  rdac_word_t word_i,
   output logic       ready_o,
   output rdac_sel_e  sel_o,
   output logic [7:0] data_o,
   output logic       wr_o
);

   localparam int unsigned MAX_A   = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
   localparam int unsigned MAX_CYC = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
   localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
   localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
   localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);

   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("rdac_bus_writer: SETUP_CYC must be at least 1");
   end
   if (STROBE_CYC < 1) begin : g_bad_strobe
      $error("rdac_bus_writer: STROBE_CYC must be at least 1");
   end
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("rdac_bus_writer: HOLD_CYC must be at least 1");
   end

   typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;
   rdac_word_t       word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         word_q  <= '{sel: SEL_ADDR, data: 8'h00};
      end else begin
         case (phase_q)
            PH_IDLE: begin
               if (load_i) begin
                  word_q  <= word_i;
                  cnt_q   <= SETUP_LD;
                  phase_q <= PH_SETUP;
               end
            end
            PH_SETUP: begin
               if (cnt_q == '0) begin
                  cnt_q   <= STROBE_LD;
                  phase_q <= PH_STROBE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_STROBE: begin
               if (cnt_q == '0) begin
                  cnt_q   <= HOLD_LD;
                  phase_q <= PH_HOLD;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               if (cnt_q == '0) begin
                  phase_q <= PH_IDLE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
         endcase
      end
   end

   assign ready_o = (phase_q == PH_IDLE);
   assign wr_o    = (phase_q == PH_STROBE);
   assign sel_o   = word_q.sel;
   assign data_o  = word_q.data;

   assert_setup_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_o) |-> ($stable(data_o) && $stable(sel_o)));

   assert_strobe_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_o && $past(wr_o)) |-> ($stable(data_o) && $stable(sel_o)));

   assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_o) |-> ($stable(data_o) && $stable(sel_o)));

   assert_no_load_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready_o) |=> $stable(data_o) || $past(ready_o));

endmodule

// File: rtl/rdac_init_seq.sv
module rdac_init_seq
   import rdac_init_pkg::*;
#(
   parameter int unsigned SETUP_CYC  = 2,
   parameter int unsigned STROBE_CYC = 1,
   parameter int unsigned HOLD_CYC   = 1,
   parameter int unsigned IDX_W      = 8,
   parameter bit          AUTO_START = 1'b0,
   parameter logic [7:0]  MASK_VAL   = 8'hFF,
   parameter logic [7:0]  CMD1_VAL   = 8'h00,
   parameter logic [7:0]  CMD2_VAL   = 8'hEC,
   parameter logic [7:0]  CMD3_VAL   = 8'hC0
)
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   output logic [7:0] bus_data_o,
   output logic [1:0] bus_sel_o,
   output logic       bus_rnw_o,
   output logic       bus_wr_o,
   output logic       busy_o,
   output logic       done_o
);

   typedef enum logic [2:0] {ST_IDLE, ST_FIXED, ST_RAMP, ST_DRAIN, ST_DONE} state_e;

   state_e            state_q;
   logic [STEP_W-1:0] step_q;
   logic              launch;
   logic              wr_ready;
   logic              wr_load;
   rdac_word_t        wr_word;
   rdac_word_t        fix_word;
   logic              fix_last;
   rdac_word_t        ramp_word;
   logic              ramp_last;
   logic              ramp_adv;
   rdac_sel_e         sel_w;

   if (AUTO_START) begin : g_auto_launch
      logic armed_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) armed_q <= 1'b1;
         else        armed_q <= 1'b0;
      end
      assign launch = armed_q | start_i;
   end else begin : g_pulse_launch
      assign launch = start_i;
   end

   rdac_fixed_steps #(
      .MASK_VAL (MASK_VAL),
      .CMD1_VAL (CMD1_VAL),
      .CMD2_VAL (CMD2_VAL),
      .CMD3_VAL (CMD3_VAL)
   ) u_fixed (
      .step_i (step_q),
      .word_o (fix_word),
      .last_o (fix_last)
   );

   rdac_ramp_gen #(
      .IDX_W (IDX_W)
   ) u_ramp (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (ramp_adv),
      .word_o (ramp_word),
      .last_o (ramp_last)
   );

   rdac_bus_writer #(
      .SETUP_CYC  (SETUP_CYC),
      .STROBE_CYC (STROBE_CYC),
      .HOLD_CYC   (HOLD_CYC)
   ) u_writer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (wr_load),
      .word_i  (wr_word),
      .ready_o (wr_ready),
      .sel_o   (sel_w),
      .data_o  (bus_data_o),
      .wr_o    (bus_wr_o)
   );

   always_comb begin
      wr_load  = 1'b0;
      ramp_adv = 1'b0;
      wr_word  = fix_word;
      if (state_q == ST_FIXED) begin
         wr_load = wr_ready;
      end else if (state_q == ST_RAMP) begin
         wr_word  = ramp_word;
         wr_load  = wr_ready;
         ramp_adv = wr_ready;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (launch) state_q <= ST_FIXED;
            end
            ST_FIXED: begin
               if (wr_ready) begin
                  step_q <= step_q + 1'b1;
                  if (fix_last) state_q <= ST_RAMP;
               end
            end
            ST_RAMP: begin
               if (wr_ready && ramp_last) state_q <= ST_DRAIN;
            end
            ST_DRAIN: begin
               if (wr_ready) state_q <= ST_DONE;
            end
            default: state_q <= ST_DONE;
         endcase
      end
   end

   assign bus_sel_o = sel_w;
   assign busy_o    = (state_q == ST_FIXED) || (state_q == ST_RAMP) || (state_q == ST_DRAIN);
   assign done_o    = (state_q == ST_DONE);
   assign bus_rnw_o = ~busy_o;

   assert_launch_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && start_i) |=> busy_o);

   assert_write_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr_o |-> (!bus_rnw_o && busy_o));

   assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> done_o);

   assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !bus_wr_o));

   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (busy_o || done_o));

endmodule

// File: tb/rdac_init_seq_bench.sv
module rdac_init_seq_bench;

   localparam int SETUP_CYC  = 2;
   localparam int STROBE_CYC = 1;
   localparam int HOLD_CYC   = 1;
   localparam int N_FIXED    = 14;
   localparam int N_TOTAL    = N_FIXED + 768;
   localparam int RUN_LIMIT  = 6000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] bus_data;
   logic [1:0] bus_sel;
   logic       bus_rnw;
   logic       bus_wr;
   logic       busy;
   logic       done;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int wcount = 0;
   int last_rise = 0;
   bit finished = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rdac_init_seq #(
      .SETUP_CYC  (SETUP_CYC),
      .STROBE_CYC (STROBE_CYC),
      .HOLD_CYC   (HOLD_CYC)
   ) u_rdac_init_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .bus_data_o (bus_data),
      .bus_sel_o  (bus_sel),
      .bus_rnw_o  (bus_rnw),
      .bus_wr_o   (bus_wr),
      .busy_o     (busy),
      .done_o     (done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // expected {sel, data} of write n
   function automatic logic [9:0] exp_word(input int n);
      case (n)
         0:  return {2'b11, 8'h09};
         1:  return {2'b11, 8'h08};
         2:  return {2'b11, 8'h09};
         3:  return {2'b11, 8'h29};
         4:  return {2'b11, 8'h09};
         5:  return {2'b00, 8'h04};
         6:  return {2'b10, 8'hFF};
         7:  return {2'b00, 8'h05};
         8:  return {2'b10, 8'h00};
         9:  return {2'b00, 8'h06};
         10: return {2'b10, 8'hEC};
         11: return {2'b00, 8'h07};
         12: return {2'b10, 8'hC0};
         13: return {2'b00, 8'h00};
         default: return {2'b01, 8'((n - N_FIXED) / 3)};
      endcase
   endfunction

   function automatic string req_of(input int n);
      if (n < 5) return "R3";
      if (n < 13) return "R4";
      return "R5";
   endfunction

   // bus monitor
   logic [9:0] prev_bus = '0;
   logic       prev_wr = 1'b0;
   int         stable_n = 0;
   int         strobe_n = 0;
   int         hold_n = 0;
   bit         hold_pend = 0;

   always @(negedge clk) begin
      logic [9:0] cur;
      cur = {bus_sel, bus_data};
      if (!rst_n) begin
         wcount    = 0;
         prev_wr   = 1'b0;
         stable_n  = 0;
         strobe_n  = 0;
         hold_n    = 0;
         hold_pend = 0;
         prev_bus  = cur;
      end else begin
         if (cur != prev_bus) begin
            if (hold_pend) begin
               chk(hold_n >= HOLD_CYC, "R7", "hold samples", hold_n, HOLD_CYC);
               hold_pend = 0;
            end
            stable_n = 1;
         end else begin
            stable_n++;
         end
         if (bus_wr && !prev_wr) begin
            chk(stable_n - 1 >= SETUP_CYC, "R6", "setup samples", stable_n - 1, SETUP_CYC);
            if (wcount < N_TOTAL) begin
               chk(cur == exp_word(wcount), req_of(wcount), $sformatf("write %0d", wcount),
                   cur, exp_word(wcount));
            end else begin
               chk(1'b0, "R10", "extra write", wcount, N_TOTAL);
            end
            chk(bus_rnw == 1'b0, "R8", "rnw at strobe", bus_rnw, 0);
            wcount++;
            last_rise = cyc;
            strobe_n = 1;
         end else if (bus_wr) begin
            strobe_n++;
         end
         if (!bus_wr && prev_wr) begin
            chk(strobe_n == STROBE_CYC, "R6", "strobe width", strobe_n, STROBE_CYC);
            hold_pend = 1;
            hold_n = 1;
         end else if (!bus_wr && hold_pend) begin
            hold_n++;
         end
         prev_wr  = bus_wr;
         prev_bus = cur;
      end
   end

   task automatic check_idle(input string req);
      chk(bus_data == 8'h00, req, "data idle", bus_data, 0);
      chk(bus_sel == 2'b00, req, "sel idle", bus_sel, 0);
      chk(bus_wr == 1'b0, req, "strobe idle", bus_wr, 0);
      chk(bus_rnw == 1'b1, req, "rnw idle", bus_rnw, 1);
      chk(busy == 1'b0, req, "busy idle", busy, 0);
      chk(done == 1'b0, req, "done idle", done, 0);
   endtask

   task automatic run_full(input bit noise);
      int n;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2", "busy after start", busy, 1);
      n = 0;
      while (!done && n < RUN_LIMIT) begin
         start = noise && (($urandom % 40) == 0);
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      chk(done == 1'b1, "R9", "done reached", done, 1);
      chk(wcount == N_TOTAL, "R5", "write count", wcount, N_TOTAL);
      chk(cyc - last_rise == STROBE_CYC + HOLD_CYC + 1, "R9", "done latency",
          cyc - last_rise, STROBE_CYC + HOLD_CYC + 1);
      chk(busy == 1'b0, "R9", "busy at done", busy, 0);
      chk(bus_rnw == 1'b1, "R8", "rnw at done", bus_rnw, 1);
   endtask

   initial begin
      int gap;
      void'($urandom(32'd7151));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_idle("R1");
      rst_n = 1'b1;
      gap = 5 + int'($urandom % 16);
      repeat (gap) @(negedge clk);
      check_idle("R1");
      chk(wcount == 0, "R1", "no writes before start", wcount, 0);

      run_full(1'b1);

      for (int k = 0; k < 4; k++) begin
         gap = 1 + int'($urandom % 10);
         repeat (gap) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      repeat (40) @(negedge clk);
      chk(done == 1'b1, "R10", "done held after start", done, 1);
      chk(wcount == N_TOTAL, "R10", "no writes after done", wcount, N_TOTAL);

      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      gap = 50 + int'($urandom % 2000);
      repeat (gap) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_idle("R11");
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      check_idle("R11");
      chk(wcount == 0, "R11", "no writes after abort", wcount, 0);

      run_full(1'b0);

      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule